// File: doc/BRIEF.md
# Host Mailbox Dual-FIFO Interface

This block is the byte-wide register window that a host uses to exchange command and response bytes with a controller core. It has two 256-byte queues. Bytes that the host writes to the data port go into a host-to-core queue. Bytes that the core pushes go into a core-to-host queue, and the host reads them back through the same data port. A small core-side push/pop interface stands in for the controller.

A control/status register gives the host the queue flags in one byte: write queue full, write queue at least half full, and read queue empty. The same byte holds an interrupt enable bit and an interrupt pending bit. A separate clear register empties either queue, or both, by bit mask. Reading the interrupt register returns the 8-bit code that the core latched with its most recent interrupt event.

The host can poll the half-full flag before it sends a burst. When that flag is clear, at least 128 slots are free.

Top module: `mbox_host_if`

## Requirements
- R1: After reset the status register (address 1) reads 0x04, the interrupt register (address 2) reads 0x00, `irq_o` is low and the core sees an empty write queue.
- R2: A host write to address 0 appends the byte to the write queue. The core pops the bytes in the order they were written.
- R3: Status bit 0 is 1 exactly when the write queue holds 256 bytes. A host data write while it is full is dropped.
- R4: Status bit 1 is 1 when the write queue holds 128 or more bytes, and 0 at 127 or fewer.
- R5: A host read of address 0 returns the head of the read queue and removes it. Bytes come back in the order the core pushed them. Status bit 2 is 1 exactly when the read queue is empty.
- R6: A host read of address 0 while the read queue is empty returns 0x00 and leaves the queue unchanged.
- R7: A host write to address 2 empties the read queue when bit 1 is set and the write queue when bit 2 is set (0x06 empties both). The other bits have no effect.
- R8: Status bit 6 is the interrupt enable. A write to address 1 loads it from data bit 6, and it reads back unchanged.
- R9: A core interrupt event sets status bit 5 (pending). A write to address 1 with bit 5 set clears it, and a write with bit 5 clear keeps it. An event in the same cycle as the clear wins.
- R10: A read of address 2 returns the code presented with the latest core interrupt event.
- R11: `irq_o` is high exactly when both the pending bit and the enable bit are set.
- R12: The flags change in the cycle that follows the push, pop or clear that changed the queue occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 control/status, 2 interrupt code (read) / clear (write) |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| core_wr_pop | input | 1 | Core removes the head of the write queue |
| core_wr_data | output | 8 | Head of the write queue |
| core_wr_empty | output | 1 | Write queue empty |
| core_rd_push | input | 1 | Core appends `core_rd_data` to the read queue |
| core_rd_data | input | 8 | Byte to append to the read queue |
| core_rd_full | output | 1 | Read queue full |
| core_rd_half | output | 1 | Read queue at least half full |
| core_irq_evt | input | 1 | Core interrupt event, one-cycle pulse |
| core_irq_code | input | 8 | Interrupt code captured with the event |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions assume single-cycle strobes. They also assume that `host_wr` and `host_rd` are never high together, because a write and a read in the same cycle would share one address. The stimulus drives every strobe at the falling edge and holds it for exactly one cycle. It never raises a host write and a host read in the same cycle. The core pops the write queue only after checking that it is not empty, with one exception: the overflow assertion is deliberately exercised by a host write to a full queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_IRQ  = 2'd2;

    localparam int ST_WFULL   = 0;
    localparam int ST_WHALF   = 1;
    localparam int ST_REMPTY  = 2;
    localparam int ST_PEND    = 5;
    localparam int ST_EN      = 6;

    localparam int CLR_RD_BIT = 1;
    localparam int CLR_WR_BIT = 2;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         half,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (s_q.cnt == CNT_W'(DEPTH));
    assign empty    = (s_q.cnt == '0);
    assign half     = (s_q.cnt >= CNT_W'(DEPTH / 2));
    assign pop_data = mem_q[s_q.rptr];

    always_comb begin
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        s_d     = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wptr = ptr_inc(s_q.wptr);
            if (do_pop)  s_d.rptr = ptr_inc(s_q.rptr);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wptr] <= push_data;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(s_q.cnt));

    // R6
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clr) |=> $stable(s_q.rptr));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       wf_full,
    input  logic       wf_half,
    input  logic       rf_empty,
    input  logic [7:0] rf_head,
    input  logic       irq_evt,
    input  logic [7:0] irq_code,
    output logic       wf_push,
    output logic       rf_pop,
    output logic       wf_clr,
    output logic       rf_clr,
    output logic       irq_o
);
    typedef struct packed {
        logic       en;
        logic       pend;
        logic [7:0] code;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     ctrl_wr;
    logic [7:0] status;

    always_comb begin
        ctrl_wr = host_wr && (host_addr == ADDR_CTRL);
        wf_push = host_wr && (host_addr == ADDR_DATA);
        rf_pop  = host_rd && (host_addr == ADDR_DATA);
        wf_clr  = host_wr && (host_addr == ADDR_IRQ) && host_wdata[CLR_WR_BIT];
        rf_clr  = host_wr && (host_addr == ADDR_IRQ) && host_wdata[CLR_RD_BIT];

        status            = '0;
        status[ST_WFULL]  = wf_full;
        status[ST_WHALF]  = wf_half;
        status[ST_REMPTY] = rf_empty;
        status[ST_PEND]   = s_q.pend;
        status[ST_EN]     = s_q.en;

        s_d = s_q;
        if (ctrl_wr) begin
            s_d.en = host_wdata[ST_EN];
            if (host_wdata[ST_PEND]) s_d.pend = 1'b0;
        end
        if (irq_evt) begin
            s_d.pend = 1'b1;
            s_d.code = irq_code;
        end

        case (host_addr)
            ADDR_DATA: host_rdata = rf_empty ? 8'h00 : rf_head;
            ADDR_CTRL: host_rdata = status;
            ADDR_IRQ:  host_rdata = s_q.code;
            default:   host_rdata = 8'h00;
        endcase

        irq_o = s_q.pend && s_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (s_q.en == $past(host_wdata[ST_EN])));

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt |=> s_q.pend);

    // R9
    pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[ST_PEND] && !irq_evt) |=> !s_q.pend);

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_evt |=> $stable(s_q.code));

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if #(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       core_wr_pop,
    output logic [7:0] core_wr_data,
    output logic       core_wr_empty,
    input  logic       core_rd_push,
    input  logic [7:0] core_rd_data,
    output logic       core_rd_full,
    output logic       core_rd_half,
    input  logic       core_irq_evt,
    input  logic [7:0] core_irq_code,
    output logic       irq_o
);
    logic       wf_full, wf_half, wf_push, wf_clr;
    logic       rf_empty, rf_pop, rf_clr;
    logic [7:0] rf_head;

    mbox_fifo #(.W(8), .DEPTH(DEPTH)) u_wr_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wf_clr),
        .push      (wf_push),
        .push_data (host_wdata),
        .pop       (core_wr_pop),
        .pop_data  (core_wr_data),
        .full      (wf_full),
        .half      (wf_half),
        .empty     (core_wr_empty)
    );

    mbox_fifo #(.W(8), .DEPTH(DEPTH)) u_rd_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rf_clr),
        .push      (core_rd_push),
        .push_data (core_rd_data),
        .pop       (rf_pop),
        .pop_data  (rf_head),
        .full      (core_rd_full),
        .half      (core_rd_half),
        .empty     (rf_empty)
    );

    mbox_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .wf_full    (wf_full),
        .wf_half    (wf_half),
        .rf_empty   (rf_empty),
        .rf_head    (rf_head),
        .irq_evt    (core_irq_evt),
        .irq_code   (core_irq_code),
        .wf_push    (wf_push),
        .rf_pop     (rf_pop),
        .wf_clr     (wf_clr),
        .rf_clr     (rf_clr),
        .irq_o      (irq_o)
    );
endmodule

// File: tb/mbox_host_if_bench.sv
module mbox_host_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       core_wr_pop = 1'b0;
    logic [7:0] core_wr_data;
    logic       core_wr_empty;
    logic       core_rd_push = 1'b0;
    logic [7:0] core_rd_data = '0;
    logic       core_rd_full, core_rd_half;
    logic       core_irq_evt = 1'b0;
    logic [7:0] core_irq_code = '0;
    logic       irq_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    mbox_host_if u_mbox_host_if (.*);

    // vector fields: op[19:18] addr[17:16] data[15:8] exp[7:0]
    // op 0 host write, 1 host read+compare, 2 core push, 3 core pop+compare
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 2'd2, 8'h00, 8'h00},  // R10 code reads 0
        {2'd0, 2'd0, 8'hA1, 8'h00},  // R2
        {2'd0, 2'd0, 8'hB2, 8'h00},  // R2
        {2'd1, 2'd1, 8'h00, 8'h04},  // R5 rf empty
        {2'd3, 2'd0, 8'h00, 8'hA1},  // R2 order
        {2'd3, 2'd0, 8'h00, 8'hB2},  // R2 order
        {2'd2, 2'd0, 8'h5C, 8'h00},  // R5
        {2'd2, 2'd0, 8'h3D, 8'h00},  // R5
        {2'd1, 2'd1, 8'h00, 8'h00},  // R5 not empty
        {2'd1, 2'd0, 8'h00, 8'h5C},  // R5 order
        {2'd1, 2'd0, 8'h00, 8'h3D},  // R5 order
        {2'd1, 2'd0, 8'h00, 8'h00},  // R6 empty read
        {2'd0, 2'd1, 8'h40, 8'h00},  // R8
        {2'd1, 2'd1, 8'h00, 8'h44}   // R8 readback
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic core_push(input logic [7:0] d);
        @(negedge clk);
        core_rd_data = d; core_rd_push = 1'b1;
        @(negedge clk);
        core_rd_push = 1'b0;
    endtask

    task automatic core_pop(output logic [7:0] d);
        @(negedge clk);
        #1 d = core_wr_data;
        core_wr_pop = 1'b1;
        @(negedge clk);
        core_wr_pop = 1'b0;
    endtask

    task automatic core_event(input logic [7:0] c, input logic ack);
        @(negedge clk);
        core_irq_code = c; core_irq_evt = 1'b1;
        if (ack) begin host_addr = 2'd1; host_wdata = 8'h60; host_wr = 1'b1; end
        @(negedge clk);
        core_irq_evt = 1'b0; host_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        host_read(2'd1, rv); check("R1 status", rv, 8'h04);
        host_read(2'd2, rv); check("R1 code", rv, 8'h00);
        check("R1 irq_o", {7'd0, irq_o}, 8'h00);
        check("R1 core_wr_empty", {7'd0, core_wr_empty}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][19:18])
                2'd0: host_write(VEC[i][17:16], VEC[i][15:8]);
                2'd1: begin
                    host_read(VEC[i][17:16], rv);
                    check($sformatf("vector %0d", i), rv, VEC[i][7:0]);
                end
                2'd2: core_push(VEC[i][15:8]);
                default: begin
                    core_pop(rv);
                    check($sformatf("vector %0d", i), rv, VEC[i][7:0]);
                end
            endcase
        end

        // R4 / R3 / R12 fill the write queue
        for (int i = 0; i < 127; i++) host_write(2'd0, 8'(i));
        host_read(2'd1, rv); check("R4 at 127", rv, 8'h44);
        @(negedge clk);
        host_addr = 2'd0; host_wdata = 8'd127; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 2'd1; host_rd = 1'b1;
        #1 check("R12 half flag next cycle", host_rdata, 8'h46);
        @(negedge clk);
        host_rd = 1'b0;
        for (int i = 128; i < 255; i++) host_write(2'd0, 8'(i));
        host_read(2'd1, rv); check("R3 at 255 not full", rv, 8'h46);
        host_write(2'd0, 8'd255);
        host_read(2'd1, rv); check("R3 full", rv, 8'h47);
        host_write(2'd0, 8'hEE);  // dropped
        for (int i = 0; i < 256; i++) begin
            core_pop(rv);
            check("R3 contents", rv, 8'(i));
        end
        check("R3 extra byte dropped", {7'd0, core_wr_empty}, 8'h01);
        host_read(2'd1, rv); check("R4 empty again", rv, 8'h44);

        // R7 selective clears
        host_write(2'd0, 8'h11); host_write(2'd0, 8'h22);
        core_push(8'h33); core_push(8'h44);
        host_write(2'd2, 8'h02);
        host_read(2'd1, rv); check("R7 read queue cleared", rv, 8'h44);
        check("R7 write queue kept", {7'd0, core_wr_empty}, 8'h00);
        core_push(8'h55);
        host_write(2'd2, 8'h04);
        check("R7 write queue cleared", {7'd0, core_wr_empty}, 8'h01);
        host_read(2'd0, rv); check("R7 read queue kept", rv, 8'h55);
        host_write(2'd0, 8'h66); core_push(8'h77);
        host_write(2'd2, 8'hF9);
        check("R7 other bits ignored wr", {7'd0, core_wr_empty}, 8'h00);
        host_read(2'd1, rv); check("R7 other bits ignored rd", rv, 8'h40);
        host_write(2'd2, 8'h06);
        check("R7 both cleared wr", {7'd0, core_wr_empty}, 8'h01);
        host_read(2'd1, rv); check("R7 both cleared rd", rv, 8'h44);

        // R9 R10 R11 interrupts
        core_event(8'h9A, 1'b0);
        host_read(2'd1, rv); check("R9 pending set", rv, 8'h64);
        check("R11 irq with enable", {7'd0, irq_o}, 8'h01);
        host_read(2'd2, rv); check("R10 code", rv, 8'h9A);
        host_write(2'd1, 8'h40);
        host_read(2'd1, rv); check("R9 bit5 clear keeps", rv, 8'h64);
        host_write(2'd1, 8'h60);
        host_read(2'd1, rv); check("R9 ack clears", rv, 8'h44);
        check("R11 irq low after ack", {7'd0, irq_o}, 8'h00);
        host_write(2'd1, 8'h00);
        core_event(8'h11, 1'b0);
        check("R11 masked", {7'd0, irq_o}, 8'h00);
        host_read(2'd1, rv); check("R8 disable readback", rv, 8'h24);
        host_read(2'd2, rv); check("R10 new code", rv, 8'h11);
        host_write(2'd1, 8'h40);
        check("R11 unmasked", {7'd0, irq_o}, 8'h01);
        host_write(2'd1, 8'h60);
        core_event(8'hC3, 1'b1);
        host_read(2'd1, rv); check("R9 event beats ack", rv, 8'h64);
        host_read(2'd2, rv); check("R10 code with ack", rv, 8'hC3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule